// File: doc/BRIEF.md
# Programmable Supervisor Output Assertion Matrix

This block drives the logical outputs of a multi-rail power supervisor. Each output watches a programmable subset of event sources: the primary (undervoltage) and secondary (undervoltage or overvoltage) flags of every voltage detector, the general-purpose logic inputs, the watchdog expiry pulses, the manual-reset line, and the states of the other outputs. Any enabled source that is high asserts the output at once. Once all of its enabled sources have gone low, the output stays asserted for a hold time picked from an eight-entry table.

A per-output cause register collects every enabled source that was high while the output was being asserted. The bits stay set until that output's clear strobe is pulsed. Each output also has a polarity bit that turns the logical state into a pin level. The analog comparators, the output driver types and the configuration bus sit outside this block. The enable masks, delay codes, polarity bits and clear strobes arrive as plain configuration inputs.

Top module: `seqmx_out_matrix`

## Requirements
- R1: Each output has a source vector of NSRC = 2*NUM_DET+NUM_GPI+NUM_WD+1+NUM_OUT bits, indexed from bit 0 in this order: det_pri[NUM_DET-1:0], det_sec[NUM_DET-1:0], gpi, wd_expire, mr, then po_active[NUM_OUT-1:0]. Output i uses mask slice src_mask[i*NSRC +: NSRC]. The output asserts when any masked source bit is high. A source whose mask bit is 0 has no effect on that output's state or cause register.
- R2: Assertion takes one clock edge. If an enabled source is high before edge k, po_active is high right after edge k.
- R3: After the last cycle with an enabled source, the output stays asserted for exactly D ticks. A tick is one pulse every TICK_DIV clocks. D = max(1, B >> DELAY_SHIFT), where B for delay codes 0..7 is 4, 250, 1000, 4000, 8000, 32000, 64000, 256000. These are units of 6.25 µs, which gives 25 µs to 1600 ms when the tick is 6.25 µs.
- R4: An enabled source that rises again while the output is holding reloads the full D for the current code.
- R5: In every cycle, the cause register of output i ORs in (source vector AND its mask). Bits that are set stay set.
- R6: A pulse on fault_clr[i] clears output i's cause register. Causes present in that same cycle are still recorded.
- R7: po_level[i] = po_active[i] XOR active_low[i].
- R8: An output used as a source acts through its state from the previous cycle. An output driven by another output asserts one edge after it.
- R9: While rst is high, all po_active bits are 0, all cause registers are 0, and po_level equals active_low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| det_pri | input | NUM_DET | Primary undervoltage flags of the detectors |
| det_sec | input | NUM_DET | Secondary threshold flags of the detectors |
| gpi | input | NUM_GPI | General-purpose logic inputs |
| wd_expire | input | NUM_WD | Watchdog expiry pulses |
| mr | input | 1 | Manual reset request |
| src_mask | input | NUM_OUT*NSRC | Per-output source enable masks |
| dly_code | input | NUM_OUT*3 | Per-output hold-time codes |
| active_low | input | NUM_OUT | Per-output polarity, 1 = active low |
| fault_clr | input | NUM_OUT | Per-output cause register clear strobes |
| po_active | output | NUM_OUT | Logical output states |
| po_level | output | NUM_OUT | Output levels after polarity |
| fault_log | output | NUM_OUT*NSRC | Per-output sticky cause registers |

## Verification
The bench keeps the default eight outputs, six detectors, four logic inputs and two watchdogs, but sets TICK_DIV to 1 and DELAY_SHIFT to 8. With these values every tick is one clock, so hold times can be counted to the exact cycle. The longest code shrinks to 1000 cycles, so all eight codes can be measured on all eight outputs. Every non-output source is swept on every output, each time alongside a disabled neighbour. Restart, same-cycle clear and set, and output chaining are each set up as directed cases.

// File: rtl/seqmx_pkg.sv
package seqmx_pkg;

   localparam int DLY_CODE_W = 3;
   localparam int HOLD_CNT_W = 18;

   // hold time in prescaler ticks for a delay code, scaled down by shift
   function automatic logic [HOLD_CNT_W-1:0] hold_ticks(input logic [DLY_CODE_W-1:0] code,
                                                       input int shift);
      logic [HOLD_CNT_W-1:0] base;
      case (code)
         3'd0:    base = 18'd4;
         3'd1:    base = 18'd250;
         3'd2:    base = 18'd1000;
         3'd3:    base = 18'd4000;
         3'd4:    base = 18'd8000;
         3'd5:    base = 18'd32000;
         3'd6:    base = 18'd64000;
         default: base = 18'd256000;
      endcase
      base = base >> shift;
      if (base == '0) base = 18'd1;
      return base;
   endfunction

endpackage

// File: rtl/seqmx_tick_gen.sv
module seqmx_tick_gen #(
   parameter int TICK_DIV = 625
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk) begin
      if (rst)               div_q <= '0;
      else if (div_q == LAST) div_q <= '0;
      else                   div_q <= div_q + 1'b1;
   end

   assign tick = (div_q == LAST);

   generate
      if (TICK_DIV > 1) begin : g_gap_chk
         AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
            tick |=> !tick); // R3
      end
   endgenerate

endmodule

// File: rtl/seqmx_src_route.sv
module seqmx_src_route #(
   parameter int NUM_DET = 6,
   parameter int NUM_GPI = 4,
   parameter int NUM_WD  = 2,
   parameter int NUM_OUT = 8,
   localparam int NSRC   = 2*NUM_DET + NUM_GPI + NUM_WD + 1 + NUM_OUT
) (
   input  logic [NUM_DET-1:0]      det_pri,
   input  logic [NUM_DET-1:0]      det_sec,
   input  logic [NUM_GPI-1:0]      gpi,
   input  logic [NUM_WD-1:0]       wd_expire,
   input  logic                    mr,
   input  logic [NUM_OUT-1:0]      fb_state,
   input  logic [NUM_OUT*NSRC-1:0] src_mask,
   output logic [NUM_OUT*NSRC-1:0] hits,
   output logic [NUM_OUT-1:0]      cond
);
   logic [NSRC-1:0] src_vec;

   // bit 0 upward: primary flags, secondary flags, gpi, watchdogs, mr, outputs
   assign src_vec = {fb_state, mr, wd_expire, gpi, det_sec, det_pri};

   genvar i;
   generate
      for (i = 0; i < NUM_OUT; i++) begin : g_out
         assign hits[i*NSRC +: NSRC] = src_vec & src_mask[i*NSRC +: NSRC];
         assign cond[i]              = |hits[i*NSRC +: NSRC];
      end
   endgenerate

endmodule

// File: rtl/seqmx_hold_chan.sv
module seqmx_hold_chan
   import seqmx_pkg::*;
#(
   parameter int NSRC        = 27,
   parameter int DELAY_SHIFT = 0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  tick,
   input  logic                  cond,
   input  logic [NSRC-1:0]       hits,
   input  logic [DLY_CODE_W-1:0] code,
   input  logic                  clr,
   output logic                  active,
   output logic [NSRC-1:0]       fault
);
   logic [HOLD_CNT_W-1:0] cnt_q;
   logic [HOLD_CNT_W-1:0] load_val;
   logic                  active_q;
   logic [NSRC-1:0]       fault_q;

   assign load_val = hold_ticks(code, DELAY_SHIFT);

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (cond) begin
         active_q <= 1'b1;
         cnt_q    <= load_val;
      end else if (active_q && tick) begin
         if (cnt_q <= 1) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   // clear drops old causes, causes of this cycle are still recorded
   always_ff @(posedge clk) begin
      if (rst) fault_q <= '0;
      else     fault_q <= (clr ? '0 : fault_q) | hits;
   end

   assign active = active_q;
   assign fault  = fault_q;

   AST_ASSERT_NEXT: assert property (@(posedge clk) disable iff (rst)
      cond |=> active); // R2
   AST_NO_EARLY_DROP: assert property (@(posedge clk) disable iff (rst)
      $fell(active) |-> !$past(cond)); // R3
   AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
      !clr |=> ((fault & $past(fault)) == $past(fault))); // R5
   AST_CAUSE_LOGGED: assert property (@(posedge clk) disable iff (rst)
      (|hits) |=> ((fault & $past(hits)) == $past(hits))); // R6

endmodule

// File: rtl/seqmx_out_matrix.sv
module seqmx_out_matrix
   import seqmx_pkg::*;
#(
   parameter int NUM_DET     = 6,
   parameter int NUM_GPI     = 4,
   parameter int NUM_WD      = 2,
   parameter int NUM_OUT     = 8,
   parameter int TICK_DIV    = 625,
   parameter int DELAY_SHIFT = 0,
   localparam int NSRC       = 2*NUM_DET + NUM_GPI + NUM_WD + 1 + NUM_OUT
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic [NUM_DET-1:0]             det_pri,
   input  logic [NUM_DET-1:0]             det_sec,
   input  logic [NUM_GPI-1:0]             gpi,
   input  logic [NUM_WD-1:0]              wd_expire,
   input  logic                           mr,
   input  logic [NUM_OUT*NSRC-1:0]        src_mask,
   input  logic [NUM_OUT*DLY_CODE_W-1:0]  dly_code,
   input  logic [NUM_OUT-1:0]             active_low,
   input  logic [NUM_OUT-1:0]             fault_clr,
   output logic [NUM_OUT-1:0]             po_active,
   output logic [NUM_OUT-1:0]             po_level,
   output logic [NUM_OUT*NSRC-1:0]        fault_log
);
   generate
      if (NUM_OUT < 1 || NUM_OUT > 16) begin : g_bad_out
         $error("seqmx_out_matrix: NUM_OUT must be 1..16");
      end
      if (NUM_DET < 1 || NUM_GPI < 1 || NUM_WD < 1) begin : g_bad_src
         $error("seqmx_out_matrix: each source group needs at least one member");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("seqmx_out_matrix: TICK_DIV must be at least 1");
      end
      if (DELAY_SHIFT < 0 || DELAY_SHIFT > HOLD_CNT_W) begin : g_bad_shift
         $error("seqmx_out_matrix: DELAY_SHIFT out of range");
      end
   endgenerate

   logic                    tick;
   logic [NUM_OUT*NSRC-1:0] hits;
   logic [NUM_OUT-1:0]      cond;
   logic [NUM_OUT-1:0]      active_vec;

   seqmx_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
      .clk  (clk),
      .rst  (rst),
      .tick (tick)
   );

   seqmx_src_route #(
      .NUM_DET (NUM_DET),
      .NUM_GPI (NUM_GPI),
      .NUM_WD  (NUM_WD),
      .NUM_OUT (NUM_OUT)
   ) i_route (
      .det_pri   (det_pri),
      .det_sec   (det_sec),
      .gpi       (gpi),
      .wd_expire (wd_expire),
      .mr        (mr),
      .fb_state  (active_vec),
      .src_mask  (src_mask),
      .hits      (hits),
      .cond      (cond)
   );

   genvar i;
   generate
      for (i = 0; i < NUM_OUT; i++) begin : g_chan
         seqmx_hold_chan #(
            .NSRC        (NSRC),
            .DELAY_SHIFT (DELAY_SHIFT)
         ) i_chan (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .cond   (cond[i]),
            .hits   (hits[i*NSRC +: NSRC]),
            .code   (dly_code[i*DLY_CODE_W +: DLY_CODE_W]),
            .clr    (fault_clr[i]),
            .active (active_vec[i]),
            .fault  (fault_log[i*NSRC +: NSRC])
         );
      end
   endgenerate

   assign po_active = active_vec;
   assign po_level  = active_vec ^ active_low;

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (po_active == '0)); // R9

endmodule

// File: tb/test_seqmx_out_matrix.sv
module test_seqmx_out_matrix;
   localparam int ND = 6, NG = 4, NW = 2, NO = 8;
   localparam int NS = 2*ND + NG + NW + 1 + NO; // 27
   localparam int NEXT = NS - NO;                // 19 non-output sources
   localparam int SHIFT = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [NEXT-1:0]  srcv = '0;
   logic [NO*NS-1:0] src_mask = '0;
   logic [NO*3-1:0]  dly_code = '0;
   logic [NO-1:0]    active_low = 8'hA5;
   logic [NO-1:0]    fault_clr = '0;
   logic [NO-1:0]    po_active, po_level;
   logic [NO*NS-1:0] fault_log;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   seqmx_out_matrix #(
      .NUM_DET(ND), .NUM_GPI(NG), .NUM_WD(NW), .NUM_OUT(NO),
      .TICK_DIV(1), .DELAY_SHIFT(SHIFT)
   ) i_seqmx_out_matrix (
      .clk(clk), .rst(rst),
      .det_pri(srcv[5:0]), .det_sec(srcv[11:6]), .gpi(srcv[15:12]),
      .wd_expire(srcv[17:16]), .mr(srcv[18]),
      .src_mask(src_mask), .dly_code(dly_code), .active_low(active_low),
      .fault_clr(fault_clr), .po_active(po_active), .po_level(po_level),
      .fault_log(fault_log)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int exp_hold(input int code);
      int tbl [8] = '{4, 250, 1000, 4000, 8000, 32000, 64000, 256000};
      int d = tbl[code] >> SHIFT;
      return (d < 1) ? 1 : d;
   endfunction

   function automatic logic [NS-1:0] flog(input int o);
      return fault_log[o*NS +: NS];
   endfunction

   // one-cycle pulse on source s, then count cycles the output stays high
   task automatic hold_len(input int o, input int s, output int cnt);
      srcv[s] = 1'b1;
      step();
      srcv[s] = 1'b0;
      cnt = 0;
      while (po_active[o] && cnt < 5000) begin
         cnt++;
         step();
      end
   endtask

   initial begin
      int n;
      @(negedge clk);
      step();
      // R9 reset state
      chk(po_active == '0, "R9 active in reset", 32'(po_active), 0);
      chk(fault_log == '0, "R9 faults in reset", 32'(fault_log[31:0]), 0);
      chk(po_level == active_low, "R9 level in reset", 32'(po_level), 32'(active_low));
      rst = 1'b0;
      step();

      // R1/R2/R5/R6/R7 sweep of every external source on every output
      for (int o = 0; o < NO; o++) begin
         for (int s = 0; s < NEXT; s++) begin
            src_mask = '0;
            src_mask[o*NS + s] = 1'b1;
            srcv[s] = 1'b1;
            step();
            chk(po_active == NO'(1 << o), "R2 assert next edge", 32'(po_active), 32'(1 << o));
            chk(po_level == (NO'(1 << o) ^ active_low), "R7 polarity", 32'(po_level),
                32'(NO'(1 << o) ^ active_low));
            chk(flog(o) == NS'(1 << s), "R5 cause logged", 32'(flog(o)), 32'(1 << s));
            srcv[s] = 1'b0;
            step();
            chk(po_active == '0, "R3 code0 release", 32'(po_active), 0);
            srcv[(s + 1) % NEXT] = 1'b1;
            step();
            srcv[(s + 1) % NEXT] = 1'b0;
            chk(po_active == '0, "R1 disabled source ignored", 32'(po_active), 0);
            chk(flog(o) == NS'(1 << s), "R1 R5 sticky and unmasked", 32'(flog(o)), 32'(1 << s));
            fault_clr[o] = 1'b1;
            step();
            fault_clr[o] = 1'b0;
            chk(flog(o) == '0, "R6 clear", 32'(flog(o)), 0);
         end
      end

      // R3 hold time for every code on every output
      for (int o = 0; o < NO; o++) begin
         src_mask = '0;
         src_mask[o*NS + 12] = 1'b1; // gpi[0]
         for (int c = 0; c < 8; c++) begin
            dly_code = '0;
            dly_code[o*3 +: 3] = 3'(c);
            hold_len(o, 12, n);
            chk(n == exp_hold(c), "R3 hold length", 32'(n), 32'(exp_hold(c)));
            step();
         end
         fault_clr = '1;
         step();
         fault_clr = '0;
      end

      // R4 restart during hold
      src_mask = '0;
      src_mask[2*NS + 18] = 1'b1; // mr
      dly_code = '0;
      dly_code[2*3 +: 3] = 3'd3;
      srcv[18] = 1'b1;
      step();
      srcv[18] = 1'b0;
      repeat (10) step();
      chk(po_active[2] == 1'b1, "R4 still holding", 32'(po_active), 32'h4);
      hold_len(2, 18, n);
      chk(n == exp_hold(3), "R4 restart full hold", 32'(n), 32'(exp_hold(3)));

      // R6 clear and new cause in the same cycle
      src_mask = '0;
      src_mask[0 +: 2] = 2'b11;
      dly_code = '0;
      fault_clr = '1;
      step();
      fault_clr = '0;
      srcv[0] = 1'b1;
      step();
      srcv[0] = 1'b0;
      chk(flog(0) == NS'(1), "R5 first cause", 32'(flog(0)), 1);
      srcv[1] = 1'b1;
      fault_clr[0] = 1'b1;
      step();
      srcv[1] = 1'b0;
      fault_clr[0] = 1'b0;
      chk(flog(0) == NS'(2), "R6 set beats clear", 32'(flog(0)), 2);
      repeat (3) step();

      // R8 output feedback, one cycle later
      src_mask = '0;
      src_mask[0*NS + 16] = 1'b1;        // wd_expire[0] on output 0
      src_mask[1*NS + NEXT + 0] = 1'b1;  // output 0 on output 1
      dly_code = '0;
      dly_code[0 +: 3] = 3'd2;
      fault_clr = '1;
      step();
      fault_clr = '0;
      srcv[16] = 1'b1;
      step();
      srcv[16] = 1'b0;
      chk(po_active[1:0] == 2'b01, "R8 chained output waits", 32'(po_active), 1);
      step();
      chk(po_active[1:0] == 2'b11, "R8 chained output follows", 32'(po_active), 3);
      chk(flog(1) == NS'(1 << NEXT), "R8 feedback cause", 32'(flog(1)), 32'(1 << NEXT));

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule